// File: doc/BRIEF.md
# Two-wire serial EEPROM target engine

This block is the target side of a two-wire serial bus in front of a 2048-byte memory that is held in registers. A system clock oversamples the bus clock and data lines. The block finds the bus start and stop conditions and decodes a device address. It then stores written bytes and returns read bytes. It drives the data line only through an open-drain style output enable, which pulls the line low when asserted.

The memory is split into eight blocks of 256 bytes. The three address bits after the fixed device type pick the block, so they are address bits and not a chip-select match. A word address byte picks a byte inside the block. Reads and writes share one 11-bit address counter. At the end of a write transaction the block sends a one-cycle commit request to a separate commit block. While that commit block reports busy, the device address is not acknowledged, so a bus master can poll until the write has finished. A write-protect input guards the upper half of the memory against data writes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high is a START. It restarts device-address reception from any state, including in the middle of a byte. A rising data line while the clock is high is a STOP. It returns the block to idle with the data line released. A partly received data byte that a START cuts off is not stored.
- R2: The first byte after START is sent MSB first. It holds the device type in bits 7:4, the block select in bits 3:1 and R/W in bit 0, where 1 means read. Only device type 4'b1010 is acknowledged. Any other type is not acknowledged, and the block stays silent until the next START.
- R3: A write-mode device address followed by a word address loads the counter with {block, word}. Each data byte that follows is acknowledged and stored at the counter address.
- R4: During writes the counter advances only in its low 4 bits, so it wraps inside a 16-byte page. After a write it holds the last written address plus one within that page.
- R5: A read-mode device address with no word address in front of it reads from the counter. The block-select bits of a read-mode device address are ignored.
- R6: A random read returns the byte at the address loaded by the word address. It consists of a write-mode device address, a word address, a repeated START and a read-mode device address.
- R7: Each byte sent adds one to the whole 11-bit counter. A sequential read therefore crosses block boundaries and wraps from 0x7FF to 0x000.
- R8: When the master does not acknowledge a read byte, the block stops sending. The data line stays released until the next START.
- R9: On a STOP after at least one stored data byte, commit_o pulses for exactly one cycle. While busy_i is high, a device address is not acknowledged.
- R10: While wp_i is high, a data byte aimed at an address with bit 10 set is not acknowledged and not stored. The rest of that transaction is ignored. Writes to the lower half still work.
- R11: Bytes are shifted MSB first. The acknowledge is driven low during the clock-low phase after the eighth falling edge. The output enable is raised only while the synchronised clock is low.
- R12: After reset the output enable and commit_o are low, every memory byte is zero and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| busy_i | input | 1 | Commit block is busy with an internal write cycle |
| wp_i | input | 1 | Protects the upper half of the memory from data writes |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| commit_o | output | 1 | One-cycle request to start the internal write cycle |

## Verification
The commit request and the acknowledge decision for a device address can meet in the same cycle. A STOP raises commit_o, and the busy report comes back while a master is already polling. The bench polls with a write-mode device address right after each write STOP and expects no acknowledge. It then waits for busy_i to fall and expects an acknowledge from the same poll. Storing a data byte and advancing the page-wrapped counter also happen on one falling edge. An 18-byte page write checks both the final memory contents and the counter that a following current-address read picks up.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_READ,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/i2c_eeprom_sync.sv
module i2c_eeprom_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges count only while the clock is high in both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_eeprom_mem.sv
module i2c_eeprom_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_eeprom_core.sv
module i2c_eeprom_core
  import i2c_eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int         BLK_W    = 3,
  parameter int         PAGE_W   = 4,
  localparam int        ADDR_W   = BLK_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic              wp_i,
  input  logic [7:0]        rdata_i,
  output logic              sda_oe_o,
  output logic              commit_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              idle_o
);
  state_e            state_q, nxt_q;
  logic [3:0]        cnt_q;
  logic              ack_q, oe_q, dirty_q, commit_q, mack_q;
  logic [7:0]        sr_q, tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BLK_W-1:0]  blk_q;
  logic              byte_done, prot;

  assign byte_done = scl_fall_i && !ack_q && (cnt_q == 4'd8);
  assign prot      = wp_i && ptr_q[ADDR_W-1];
  assign we_o      = byte_done && (state_q == ST_WDATA) && !prot;
  assign addr_o    = ptr_q;
  assign wdata_o   = sr_q;
  assign sda_oe_o  = oe_q;
  assign commit_o  = commit_q;
  assign idle_o    = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      oe_q     <= 1'b0;
      dirty_q  <= 1'b0;
      commit_q <= 1'b0;
      mack_q   <= 1'b0;
      sr_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      blk_q    <= '0;
    end else begin
      commit_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
        if (dirty_q) begin
          commit_q <= 1'b1;
          dirty_q  <= 1'b0;
        end
      end else begin
        case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise_i && !ack_q && cnt_q != 4'd8) begin
              sr_q  <= {sr_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end
            if (byte_done) begin
              ack_q <= 1'b1;
              if (state_q == ST_DEV) begin
                if (sr_q[7:4] == DEV_TYPE && !busy_i) begin
                  oe_q  <= 1'b1;
                  nxt_q <= sr_q[0] ? ST_READ : ST_WADDR;
                  if (!sr_q[0]) blk_q <= sr_q[BLK_W:1];
                end else begin
                  state_q <= ST_WAIT;
                  ack_q   <= 1'b0;
                end
              end else if (state_q == ST_WADDR) begin
                ptr_q <= {blk_q, sr_q};
                oe_q  <= 1'b1;
                nxt_q <= ST_WDATA;
              end else if (prot) begin
                state_q <= ST_WAIT;
                ack_q   <= 1'b0;
              end else begin
                oe_q    <= 1'b1;
                dirty_q <= 1'b1;
                nxt_q   <= ST_WDATA;
                ptr_q   <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
              end
            end else if (scl_fall_i && ack_q) begin
              ack_q   <= 1'b0;
              cnt_q   <= '0;
              state_q <= nxt_q;
              if (nxt_q == ST_READ) begin
                tx_q  <= {rdata_i[6:0], 1'b0};
                oe_q  <= ~rdata_i[7];
                ptr_q <= ptr_q + 1'b1;
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_READ: begin
            if (scl_rise_i) begin
              if (!ack_q) cnt_q <= cnt_q + 4'd1;
              else        mack_q <= ~sda_i;
            end
            if (scl_fall_i) begin
              if (!ack_q) begin
                if (cnt_q == 4'd8) begin
                  oe_q  <= 1'b0;
                  ack_q <= 1'b1;
                end else begin
                  oe_q <= ~tx_q[7];
                  tx_q <= {tx_q[6:0], 1'b0};
                end
              end else begin
                ack_q <= 1'b0;
                cnt_q <= '0;
                if (mack_q) begin
                  tx_q  <= {rdata_i[6:0], 1'b0};
                  oe_q  <= ~rdata_i[7];
                  ptr_q <= ptr_q + 1'b1;
                end else begin
                  state_q <= ST_WAIT;
                  oe_q    <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         BLK_W       = 3,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic busy_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic commit_o
);
  localparam int ADDR_W = BLK_W + 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic mem_we, idle;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  i2c_eeprom_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_eeprom_core #(.DEV_TYPE(DEV_TYPE), .BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_core (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .busy_i, .wp_i, .rdata_i(mem_rdata),
    .sda_oe_o, .commit_o, .we_o(mem_we), .addr_o(mem_addr), .wdata_o(mem_wdata),
    .idle_o(idle)
  );

  i2c_eeprom_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .addr_i(mem_addr), .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic sda_oe_i,
  input logic commit_i,
  input logic stop_i,
  input logic mem_we_i,
  input logic mem_msb_i,
  input logic wp_i,
  input logic idle_i
);
  // R11
  oe_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);
  // R9
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i);
  // R9
  commit_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(stop_i));
  // R10
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !(wp_i && mem_msb_i));
  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_i);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .commit_i(commit_o), .stop_i(stop_det), .mem_we_i(mem_we),
  .mem_msb_i(mem_addr[ADDR_W-1]), .wp_i(wp_i), .idle_i(idle)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0, wp = 1'b0;
  logic sda_oe, commit, sda_line;
  int busy_cnt = 0, commits = 0;
  int checks = 0, fails = 0;
  logic [7:0] exp_mem [2048];
  logic [10:0] cur = '0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .busy_i(busy), .wp_i(wp), .sda_oe_o(sda_oe), .commit_o(commit)
  );

  // commit block model
  always @(posedge clk) begin
    if (commit) begin
      busy     <= 1'b1;
      busy_cnt <= BUSY_CYC;
      commits  <= commits + 1;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [10:0] a, input logic [7:0] s);
    return a[7:0] * 8'd13 + {5'b0, a[10:8]} * 8'd29 + s;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wcyc(4); scl_m = 1'b1; wcyc(4); sda_m = 1'b0; wcyc(4); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wcyc(2); sda_m = 1'b0; wcyc(2); scl_m = 1'b1; wcyc(4); sda_m = 1'b1; wcyc(4);
  endtask

  task automatic send_bit(input logic b);
    wcyc(2); sda_m = b; wcyc(2); scl_m = 1'b1; wcyc(4); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wcyc(4); scl_m = 1'b1; wcyc(3); b = sda_line; wcyc(1); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic page_write(input logic [10:0] a, input int n, input logic [7:0] s);
    logic ack;
    logic [10:0] p;
    int c0;
    c0 = commits;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack);
    chk(ack, "R2 device address ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R3 word address ack", ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      send_byte(pat(p, s), ack);
      chk(ack, "R3 data ack", ack, 1);
      exp_mem[p] = pat(p, s);
      p = {p[10:4], p[3:0] + 4'd1};
    end
    bus_stop();
    cur = p;
    wcyc(4);
    chk(commits == c0 + 1, "R9 one commit per write", commits - c0, 1);
  endtask

  task automatic poll(output logic ack);
    bus_start();
    send_byte(8'hA0, ack);
    bus_stop();
  endtask

  task automatic wait_commit();
    logic ack;
    poll(ack);
    chk(!ack, "R9 busy poll nack", ack, 0);
    while (busy) wcyc(1);
    poll(ack);
    chk(ack, "R9 ready poll ack", ack, 1);
  endtask

  task automatic read_run(input logic [10:0] a, input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      chk(d == exp_mem[a + 11'(i)], tag, d, exp_mem[a + 11'(i)]);
    end
    bus_stop();
    cur = a + 11'(n);
  endtask

  task automatic rand_read(input logic [10:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack);
    chk(ack, "R6 write-mode address ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R6 word address ack", ack, 1);
    bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R6 read-mode address ack", ack, 1);
    read_run(a, n, tag);
  endtask

  task automatic cur_read(input logic [2:0] blk, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({4'b1010, blk, 1'b1}, ack);
    chk(ack, "R5 read address ack", ack, 1);
    read_run(cur, n, tag);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 2048; i++) exp_mem[i] = 8'h00;
    wcyc(3);
    chk(sda_oe == 1'b0, "R12 reset oe", sda_oe, 0);
    chk(commit == 1'b0, "R12 reset commit", commit, 0);
    rst_n = 1'b1;
    wcyc(4);

    // R12 counter and memory zero after reset
    cur_read(3'b000, 2, "R12 reset contents");

    // R3 full page in each block, with busy polling
    for (int b = 0; b < 8; b++) begin
      page_write(11'(b * 256 + b * 16), 16, 8'(b * 3 + 1));
      wait_commit();
    end
    for (int b = 0; b < 8; b++) rand_read(11'(b * 256 + b * 16), 16, "R6 R11 random read");

    // R7 crossing a block boundary
    rand_read(11'h0FE, 20, "R7 block crossing");
    // R7 wrap at end of memory
    page_write(11'h7F0, 16, 8'h55);
    wait_commit();
    rand_read(11'h7FE, 4, "R7 end wrap");
    // R5 current read, block bits ignored
    cur_read(3'b101, 1, "R5 current address read");

    // R4 page wrap with 18 bytes
    page_write(11'h20E, 18, 8'h9C);
    wait_commit();
    chk(cur == 11'h200, "R4 counter model", cur, 11'h200);
    cur_read(3'b000, 2, "R4 counter after page wrap");
    rand_read(11'h200, 16, "R4 page contents");

    // R10 write protect
    wp = 1'b1;
    c0 = commits;
    bus_start();
    send_byte(8'hA8, ack);
    chk(ack, "R10 address ack", ack, 1);
    send_byte(8'h40, ack);
    chk(ack, "R10 word ack", ack, 1);
    send_byte(8'hEE, ack);
    chk(!ack, "R10 protected data nack", ack, 0);
    bus_stop();
    wcyc(4);
    chk(commits == c0, "R10 no commit", commits - c0, 0);
    rand_read(11'h440, 1, "R10 protected unchanged");
    page_write(11'h010, 2, 8'h71);
    wait_commit();
    rand_read(11'h010, 2, "R10 lower half writable");
    wp = 1'b0;

    // R2 wrong device type
    bus_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R2 wrong type nack", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R2 silent after mismatch", ack, 0);
    bus_stop();

    // R8 master nack ends transmission
    rand_read(11'h130, 1, "R8 single byte");
    cur = 11'h131;
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(d, 1'b0);
    chk(d == exp_mem[11'h131], "R8 byte before nack", d, exp_mem[11'h131]);
    recv_byte(d, 1'b0);
    chk(d == 8'hFF, "R8 line released after nack", d, 8'hFF);
    bus_stop();

    // R1 start mid-byte and mid-data abort
    c0 = commits;
    bus_start();
    send_byte(8'hA6, ack);
    send_byte(8'h00, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start();
    bus_stop();
    wcyc(4);
    chk(commits == c0, "R1 aborted byte no commit", commits - c0, 0);
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    rand_read(11'h300, 1, "R1 aborted byte not stored");
    rand_read(11'h330, 3, "R1 restart mid-byte read");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule